// File: doc/BRIEF.md
# Training-Pattern Lane Word Aligner

This block finds the word boundary on each of eight deserialized lanes of a source-synchronous ADC link that carries no frame clock. Each lane delivers one raw 8-bit word per word clock. During training the converter repeats a fixed word, 0x0F. Each lane has its own search machine. It moves the lane's bit boundary by one position at a time until the training word has been seen steadily, then keeps that boundary. Lane pairs are then merged into one 16-bit sample per channel, which gives four channels.

Alignment runs once after power-up. It starts after the converter has been set to two lanes per channel and told to emit its training word. The system raises the training flag, pulses the start request, waits for every lane to report locked, and then clears the training flag. From that point samples are marked valid. A lane that cannot find the word within two full rotations of its boundary reports an error and stops searching.

Each lane machine has five states. Idle holds after reset. Settle waits out the pipeline after a start or a slip. Check compares the aligned word with the training word. Locked holds a frozen offset. Failed is terminal. The transitions are as follows. start moves any state to Settle. settle-done moves Settle to Check. match-run-complete moves Check to Locked. mismatch moves Check to Settle and advances the offset. slips-exhausted moves Check to Failed.

Top module: `lwa_aligner`

## Requirements
- R1: Lane l takes its raw word on raw_i[8l+7:8l]. With slip offset k, the lane's aligned word is the low 8 bits of {previous raw word, current raw word} shifted right by k. That equals {prev[k-1:0], cur[7:k]}, so a lane held at a constant raw word R yields R rotated right by k.
- R2: A start_i pulse sampled at a clock edge does four things on that edge. It clears every lane's locked and error flags, sets every offset to 0, clears the slip and match counts, and puts every lane in Settle.
- R3: After a start or a slip, a lane spends exactly 4 word clocks in Settle before its next comparison.
- R4: When a lane's aligned word differs from 0x0F during Check, the lane moves its offset up by one, wrapping modulo 8, and returns to Settle.
- R5: A lane locks after 8 consecutive aligned words equal to 0x0F. A lane whose correct offset is d shows lock_o[l] high from the 12+5d-th edge after the start edge onward, and low before that.
- R6: A lane that has made 16 slips and then sees one more mismatch enters Failed. Its err_o[l] goes high on the 85th edge after the start edge. Locked and error are never high together on a lane, and both hold until the next start.
- R7: After lock, a lane's offset stays frozen, so later data words pass through with the locked offset until the next start.
- R8: Channel c outputs on sample_o[16c+15:16c]. Lane 2c's aligned word forms the upper byte and lane 2c+1's the lower byte, and both are registered on the same edge. A raw change appears on sample_o three edges later.
- R9: valid_o is registered. It is high on the edge after a cycle in which all 8 lanes are locked and train_i is low, and low otherwise.
- R10: During and right after reset, sample_o, valid_o, lock_o and err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-alignment request, one-cycle pulse |
| train_i | input | 1 | High while the converter sends the training word |
| raw_i | input | 64 | Raw deserialized words, lane l on bits [8l+7:8l] |
| sample_o | output | 64 | Aligned samples, channel c on bits [16c+15:16c] |
| valid_o | output | 1 | Sample valid |
| lock_o | output | 8 | Per-lane locked flag |
| err_o | output | 8 | Per-lane alignment error flag |

## Verification
Two events can land in the same cycle: the last lane reaching lock and the sample-valid decision. A start request can also fall while valid is already high. Both cases are provoked by clearing train_i before training, so valid rises straight from the final lock. The bench expects valid exactly one edge after the slowest lane's computed lock edge, and expects it low on the second edge after a restart issued from the valid state. Lock and error timing per lane are judged against 12+5d and 85 edges, computed from the chosen offsets.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CHECK,
        ST_LOCKED,
        ST_FAILED
    } lane_state_e;
endpackage

// File: rtl/lwa_slip_window.sv
module lwa_slip_window #(
    parameter int W  = 8,
    parameter int OW = $clog2(W)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  raw_i,
    input  logic [OW-1:0] off_i,
    output logic [W-1:0]  win_o
);
    logic [W-1:0]   prev_q;
    logic [W-1:0]   win_q;
    logic [2*W-1:0] cat_sh;

    // older word in the upper half, shift right by the slip offset
    assign cat_sh = {prev_q, raw_i} >> off_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
            win_q  <= '0;
        end else begin
            prev_q <= raw_i;
            win_q  <= cat_sh[W-1:0];
        end
    end

    assign win_o = win_q;
endmodule

// File: rtl/lwa_lane_fsm.sv
module lwa_lane_fsm
    import lwa_pkg::*;
#(
    parameter int          W         = 8,
    parameter logic [W-1:0] TRAIN    = 8'h0F,
    parameter int          SETTLE    = 4,
    parameter int          LOCK_RUN  = 8,
    parameter int          MAX_SLIPS = 2 * W,
    parameter int          OW        = $clog2(W)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [W-1:0]  win_i,
    output logic [OW-1:0] off_o,
    output logic          lock_o,
    output logic          err_o
);
    localparam int SCW = $clog2(SETTLE + 1);
    localparam int MCW = $clog2(LOCK_RUN + 1);
    localparam int SLW = $clog2(MAX_SLIPS + 1);

    lane_state_e    state_q, state_d;
    logic [SCW-1:0] settle_q;
    logic [MCW-1:0] match_q;
    logic [SLW-1:0] slips_q;
    logic [OW-1:0]  off_q;
    logic           hit;
    logic           settle_done;
    logic           run_done;
    logic           slips_out;

    assign hit         = (win_i == TRAIN);
    assign settle_done = (settle_q == SCW'(SETTLE - 1));
    assign run_done    = (match_q == MCW'(LOCK_RUN - 1));
    assign slips_out   = (slips_q == SLW'(MAX_SLIPS));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_SETTLE: if (settle_done) state_d = ST_CHECK;
            ST_CHECK: begin
                if (hit) begin
                    if (run_done) state_d = ST_LOCKED;
                end else if (slips_out) begin
                    state_d = ST_FAILED;
                end else begin
                    state_d = ST_SETTLE;
                end
            end
            ST_LOCKED: state_d = ST_LOCKED;
            ST_FAILED: state_d = ST_FAILED;
            default:   state_d = ST_IDLE;
        endcase
        if (start_i) state_d = ST_SETTLE;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // counters and slip offset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            settle_q <= '0;
            match_q  <= '0;
            slips_q  <= '0;
            off_q    <= '0;
        end else if (start_i) begin
            settle_q <= '0;
            match_q  <= '0;
            slips_q  <= '0;
            off_q    <= '0;
        end else begin
            unique case (state_q)
                ST_SETTLE: settle_q <= settle_done ? '0 : settle_q + SCW'(1);
                ST_CHECK: begin
                    if (hit) begin
                        match_q <= match_q + MCW'(1);
                    end else begin
                        match_q <= '0;
                        if (!slips_out) begin
                            off_q   <= off_q + OW'(1);
                            slips_q <= slips_q + SLW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        off_o  = off_q;
        lock_o = (state_q == ST_LOCKED);
        err_o  = (state_q == ST_FAILED);
    end
endmodule

// File: rtl/lwa_sample_pack.sv
module lwa_sample_pack #(
    parameter int LANES = 8,
    parameter int W     = 8,
    parameter int CH    = LANES / 2,
    parameter int SW    = 2 * W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [LANES*W-1:0] win_i,
    input  logic [LANES-1:0]   lock_i,
    input  logic               train_i,
    output logic [CH*SW-1:0]   sample_o,
    output logic               valid_o
);
    logic valid_q;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [SW-1:0] smp_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) smp_q <= '0;
            else         smp_q <= {win_i[(2*c)*W +: W], win_i[(2*c+1)*W +: W]};
        end
        assign sample_o[c*SW +: SW] = smp_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) valid_q <= 1'b0;
        else         valid_q <= (&lock_i) & ~train_i;
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/lwa_aligner.sv
module lwa_aligner #(
    parameter int          LANES    = 8,
    parameter int          W        = 8,
    parameter logic [W-1:0] TRAIN   = 8'h0F,
    parameter int          SETTLE   = 4,
    parameter int          LOCK_RUN = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic                 train_i,
    input  logic [LANES*W-1:0]   raw_i,
    output logic [LANES*W-1:0]   sample_o,
    output logic                 valid_o,
    output logic [LANES-1:0]     lock_o,
    output logic [LANES-1:0]     err_o
);
    localparam int OW = $clog2(W);

    logic [LANES*W-1:0] win_all;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [OW-1:0] off;

        lwa_slip_window #(.W(W), .OW(OW)) win_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .raw_i  (raw_i[l*W +: W]),
            .off_i  (off),
            .win_o  (win_all[l*W +: W])
        );

        lwa_lane_fsm #(
            .W(W), .TRAIN(TRAIN), .SETTLE(SETTLE),
            .LOCK_RUN(LOCK_RUN), .MAX_SLIPS(2 * W), .OW(OW)
        ) fsm_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (start_i),
            .win_i   (win_all[l*W +: W]),
            .off_o   (off),
            .lock_o  (lock_o[l]),
            .err_o   (err_o[l])
        );
    end

    lwa_sample_pack #(.LANES(LANES), .W(W), .CH(LANES / 2), .SW(2 * W)) pack_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .win_i    (win_all),
        .lock_i   (lock_o),
        .train_i  (train_i),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );
endmodule

// File: rtl/lwa_aligner_chk.sv
module lwa_aligner_chk #(
    parameter int LANES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             train_i,
    input logic             valid_o,
    input logic [LANES-1:0] lock_o,
    input logic [LANES-1:0] err_o
);
    // R6: locked and error exclusive per lane
    a_r6_lock_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_o & err_o) == '0);

    // R2: start clears all flags on the next edge
    a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (lock_o == '0 && err_o == '0));

    // R7: a lock is kept until a start
    a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ((lock_o & $past(lock_o)) == $past(lock_o)));

    // R6: an error is kept until a start
    a_r6_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ((err_o & $past(err_o)) == $past(err_o)));

    // R9: valid only after all lanes locked with training flag low
    a_r9_valid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past((&lock_o) && !train_i));

    // R9: all locked with training low yields valid next edge
    a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&lock_o) && !train_i && !start_i) |=> valid_o);
endmodule

bind lwa_aligner lwa_aligner_chk #(.LANES(LANES)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .train_i (train_i),
    .valid_o (valid_o),
    .lock_o  (lock_o),
    .err_o   (err_o)
);

// File: tb/lwa_aligner_tb_top.sv
module lwa_aligner_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        train_i = 1'b1;
    logic [63:0] raw_q = '0;
    logic [63:0] raw_i;
    logic [63:0] sample_o;
    logic        valid_o;
    logic [7:0]  lock_o;
    logic [7:0]  err_o;
    logic        alt_en = 1'b0;
    logic        alt_tog = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk_i = ~clk_i;

    always @(negedge clk_i) alt_tog <= ~alt_tog;

    // lane 5 alternates between the training word and 0xAA when enabled
    assign raw_i = alt_en ? {raw_q[63:48], (alt_tog ? 8'h0F : 8'hAA), raw_q[39:0]} : raw_q;

    lwa_aligner dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .train_i(train_i),
        .raw_i(raw_i), .sample_o(sample_o), .valid_o(valid_o),
        .lock_o(lock_o), .err_o(err_o)
    );

    // per-lane offsets for each vector, and whether train_i is low during search
    localparam logic [2:0] D_TAB [0:3][0:7] = '{
        '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
        '{3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
        '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd3, 3'd0, 3'd7, 3'd7, 3'd1, 3'd5, 3'd2, 3'd4}
    };
    localparam logic TL_TAB [0:3] = '{1'b0, 1'b1, 1'b1, 1'b0};

    function automatic logic [7:0] rotl8(logic [7:0] v, int k);
        logic [15:0] t;
        t = {v, v} << k;
        return t[15:8];
    endfunction

    function automatic logic [7:0] rotr8(logic [7:0] v, int k);
        logic [15:0] t;
        t = {v, v} >> k;
        return t[7:0];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk_i) start_i = 1'b1;
        @(posedge clk_i);
        #1 start_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int lock_at [8];
        int valid_at;
        int err_at;
        int dmax;
        logic [7:0] dv [8];
        logic [63:0] exp_s;

        // R10: reset state
        repeat (3) @(posedge clk_i);
        #1;
        chk("R10 sample", sample_o, 64'h0);
        chk("R10 valid", {63'h0, valid_o}, 64'h0);
        chk("R10 lock/err", {48'h0, lock_o, err_o}, 64'h0);
        @(negedge clk_i) rst_ni = 1'b1;
        repeat (4) @(posedge clk_i);
        #1;
        chk("R10 after release", {valid_o, 39'h0, lock_o, err_o, 8'h0}, 64'h0);

        // table of offset vectors
        for (int e = 0; e < 4; e++) begin
            @(negedge clk_i);
            train_i = !TL_TAB[e];
            for (int l = 0; l < 8; l++) raw_q[l*8 +: 8] = rotl8(8'h0F, int'(D_TAB[e][l]));
            pulse_start();
            for (int l = 0; l < 8; l++) lock_at[l] = 0;
            valid_at = 0;
            for (int n = 1; n <= 200; n++) begin
                @(posedge clk_i);
                #1;
                if (n == 1) chk("R2 start clears", {48'h0, lock_o, err_o}, 64'h0);
                if (n == 2) chk("R9 valid drops after restart", {63'h0, valid_o}, 64'h0);
                for (int l = 0; l < 8; l++)
                    if (lock_o[l] && lock_at[l] == 0) lock_at[l] = n;
                if (n > 2 && valid_o && valid_at == 0) valid_at = n;
            end
            dmax = 0;
            for (int l = 0; l < 8; l++) begin
                // R3 R4 R5: lock edge 12 + 5d
                chk("R5 lock edge", 64'(lock_at[l]), 64'(12 + 5 * int'(D_TAB[e][l])));
                if (int'(D_TAB[e][l]) > dmax) dmax = int'(D_TAB[e][l]);
            end
            // R9: valid follows last lock by one edge when train_i low, else never
            chk("R9 valid edge", 64'(valid_at), TL_TAB[e] ? 64'(13 + 5 * dmax) : 64'h0);
            @(negedge clk_i) train_i = 1'b0;
            repeat (3) @(posedge clk_i);
            #1;
            chk("R9 valid after train low", {47'h0, valid_o, lock_o, err_o}, {47'h0, 1'b1, 8'hFF, 8'h00});

            // data pass-through with frozen offsets
            for (int j = 0; j < 3; j++) begin
                @(negedge clk_i);
                for (int l = 0; l < 8; l++) begin
                    dv[l] = 8'(8'h3C + l * 29 + j * 71 + e * 13);
                    raw_q[l*8 +: 8] = dv[l];
                end
                repeat (3) @(posedge clk_i);
                #1;
                for (int c = 0; c < 4; c++)
                    exp_s[c*16 +: 16] = {rotr8(dv[2*c], int'(D_TAB[e][2*c])),
                                         rotr8(dv[2*c+1], int'(D_TAB[e][2*c+1]))};
                chk("R1 R7 R8 sample", sample_o, exp_s);
                chk("R7 lock kept", {56'h0, lock_o}, 64'hFF);
            end
        end

        // R6: lane 3 never sees a rotation of the training word
        @(negedge clk_i);
        for (int l = 0; l < 8; l++) raw_q[l*8 +: 8] = rotl8(8'h0F, 2);
        raw_q[31:24] = 8'h00;
        pulse_start();
        err_at = 0;
        for (int n = 1; n <= 120; n++) begin
            @(posedge clk_i);
            #1;
            if (err_o[3] && err_at == 0) err_at = n;
        end
        chk("R6 error edge", 64'(err_at), 64'd85);
        chk("R6 lock/err flags", {48'h0, lock_o, err_o}, {48'h0, 8'hF7, 8'h08});
        chk("R9 no valid with failed lane", {63'h0, valid_o}, 64'h0);

        // R2: restart clears the error
        @(negedge clk_i) raw_q[31:24] = rotl8(8'h0F, 2);
        pulse_start();
        @(posedge clk_i);
        #1;
        chk("R2 error cleared", {56'h0, err_o}, 64'h0);
        repeat (40) @(posedge clk_i);
        #1;
        chk("R2 relock", {48'h0, lock_o, err_o}, {48'h0, 8'hFF, 8'h00});

        // R5: alternating lane never gets 8 matches in a row
        @(negedge clk_i) alt_en = 1'b1;
        pulse_start();
        repeat (150) @(posedge clk_i);
        #1;
        chk("R5 alternating lane fails", {48'h0, lock_o, err_o}, {48'h0, 8'hDF, 8'h20});
        @(negedge clk_i) alt_en = 1'b0;

        finish_run();
    end
endmodule